// File: doc/BRIEF.md
# Cross-Triggered Event Counter Bank

This block holds a bank of event counters that share one register port and one interrupt line. Each counter watches one of several event lines. It counts either every cycle in which that line is high or, in threshold mode, every high pulse that lasts longer than a programmed (and optionally doubled) number of cycles. Software programs each counter through a local control word and the whole bank through a global control word. It reads the counts back one cycle after presenting an address.

Counters can gate one another. A counter can be held until a chosen peer changes value. A counter can also be stopped for good when a chosen peer overflows. Overflow means the counter's top bit going to 1. An enabled overflow can raise the interrupt output and, if software asks, freeze the whole bank until the condition is cleared.

Top module: `tec_top`

## Requirements
- R1: After reset every counter value, every control word and the global word read as zero, and `irq_o` is low.
- R2: A running counter with threshold mode off rises by exactly one for each clock cycle in which its selected event line (control bits [3:0] give the line index) is high. Lines it has not selected have no effect on it.
- R3: A write to a counter's value in the same cycle as a qualifying event stores the written value, and the increment is lost.
- R4: Nothing counts while the counter's own freeze bit (control bit 5) is set or while the global freeze-all bit (global bit 0) is set. Counting resumes once both bits are clear.
- R5: With trigger-on set (control bit 6), a write to the control word makes the counter hold its value. It holds until the counter named by control bits [10:8] changes value. After that it counts normally.
- R6: With trigger-off set (control bit 7), the counter stops once the counter named by control bits [13:11] has its top bit go from 0 to 1. It stays stopped, even if that peer is later cleared, until its own control word is written again.
- R7: A counter's overflow condition is its top bit being 1 while its overflow-enable (control bit 4) is set. `irq_o` goes high one cycle after any condition exists while the global interrupt enable (global bit 1) is set. It goes low one cycle after the top bit is written to 0, the overflow-enable is cleared, or the interrupt enable is cleared. With overflow-enable clear, an overflow never raises `irq_o`.
- R8: With the global freeze-on-interrupt bit (global bit 2) and the interrupt enable both set, every counter is frozen while any overflow condition exists. With the interrupt enable clear, the freeze-on-interrupt bit has no effect.
- R9: In threshold mode (control bit 14), the threshold is control bits [23:16]. It is doubled when control bit 15 is set. Each high pulse on the selected line adds exactly one to the count if its length in cycles is greater than the scaled threshold, and adds nothing otherwise.
- R10: Address 0 is the global word. Address 8+i is the value of counter i. Address 16+i is the control word of counter i. `rdata` shows the addressed register on the cycle after `addr` is presented. Writes use the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | NEV | Event lines, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for writes and reads |
| wdata | input | CW | Write data |
| rdata | output | CW | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A wrong gate state is a waiting, running or stopped condition held in error. It shows as a counter value that is off when read back after the next pulse on its event line. Pulses are spaced several cycles apart, so a one-cycle trigger delay does not hide such an error. A wrong overflow or freeze decision shows on `irq_o` within one cycle of the triggering write or pulse. It also shows as frozen or moving counts in the next read. Threshold errors show as an off-by-one count after a single pulse whose length sits exactly at, or one cycle past, the scaled threshold.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int ADDR_W = 5;
  localparam int LCTL_W = 24;
  localparam int RUN_W  = 10;

  localparam logic [1:0] REG_GLB = 2'b00;
  localparam logic [1:0] REG_VAL = 2'b01;
  localparam logic [1:0] REG_CTL = 2'b10;

  typedef enum logic [1:0] {
    GATE_RUN  = 2'd0,
    GATE_WAIT = 2'd1,
    GATE_STOP = 2'd2
  } gate_e;

  // per-counter control word, bit 23 down to bit 0
  typedef struct packed {
    logic [7:0] thr;
    logic       tmult;
    logic       tmode;
    logic [2:0] toff_sel;
    logic [2:0] ton_sel;
    logic       toff_en;
    logic       ton_en;
    logic       frz;
    logic       ovf_en;
    logic [3:0] evsel;
  } lctl_t;

  // global control word, bit 2 down to bit 0
  typedef struct packed {
    logic frz_on_irq;
    logic irq_en;
    logic frz_all;
  } gctl_t;
endpackage

// File: rtl/tec_glob.sv
module tec_glob
  import tec_pkg::*;
#(
  parameter int NCNT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_glb,
  input  logic [2:0]      wbits,
  input  logic [NCNT-1:0] cond_i,
  output gctl_t           gctl_o,
  output logic            frz_o,
  output logic            irq_o
);
  gctl_t gctl_q;
  logic  any_cond;

  assign any_cond = |cond_i;
  assign gctl_o   = gctl_q;
  assign frz_o    = gctl_q.frz_all | (gctl_q.frz_on_irq & gctl_q.irq_en & any_cond);

  always_ff @(posedge clk) begin
    if (rst) begin
      gctl_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_glb) gctl_q <= gctl_t'(wbits);
      irq_o <= gctl_q.irq_en & any_cond;
    end
  end

  // R7: interrupt enable off means no request on the next cycle
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !gctl_q.irq_en |=> !irq_o);
  // R7: a request always has an overflow condition behind it
  assert_irq_src_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(any_cond));
endmodule

// File: rtl/tec_slot.sv
module tec_slot
  import tec_pkg::*;
#(
  parameter int NCNT = 6,
  parameter int CW   = 32,
  parameter int NEV  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_val,
  input  logic            wr_ctl,
  input  logic [CW-1:0]   wdata,
  input  logic [NEV-1:0]  ev_i,
  input  logic [NCNT-1:0] chg_all,
  input  logic [NCNT-1:0] ovf_all,
  input  logic            frz_all,
  output logic [CW-1:0]   cnt_o,
  output logic [CW-1:0]   ctl_o,
  output logic            chg_o,
  output logic            ovf_o,
  output logic            cond_o
);
  lctl_t            ctl_q;
  lctl_t            ctl_new;
  gate_e            st_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_d;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_d;
  logic [RUN_W-1:0] thr_scaled;
  logic             ev_hit;
  logic             on_hit;
  logic             off_hit;
  logic             hit;
  logic             cnt_en;
  logic             chg_q;
  logic             ovf_q;

  assign ctl_new = lctl_t'(wdata[LCTL_W-1:0]);

  // select the event line and the two peer signals
  always_comb begin
    ev_hit  = 1'b0;
    on_hit  = 1'b0;
    off_hit = 1'b0;
    for (int k = 0; k < NEV; k++)
      if (ctl_q.evsel == 4'(k)) ev_hit = ev_i[k];
    for (int k = 0; k < NCNT; k++) begin
      if (ctl_q.ton_sel == 3'(k))  on_hit  = chg_all[k];
      if (ctl_q.toff_sel == 3'(k)) off_hit = ovf_all[k];
    end
  end

  // pulse length tracking for threshold mode
  assign thr_scaled = ctl_q.tmult ? {1'b0, ctl_q.thr, 1'b0} : {2'b00, ctl_q.thr};

  always_comb begin
    if (!ev_hit)           run_d = '0;
    else if (run_q != '1)  run_d = run_q + 1'b1;
    else                   run_d = run_q;
  end

  assign hit    = ctl_q.tmode ? (ev_hit && (run_q == thr_scaled)) : ev_hit;
  assign cnt_en = (st_q == GATE_RUN) && !ctl_q.frz && !frz_all;

  always_comb begin
    if (wr_val)              cnt_d = wdata;
    else if (hit && cnt_en)  cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ctl_q <= '0;
      run_q <= '0;
      st_q  <= GATE_RUN;
      chg_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      chg_q <= (cnt_d != cnt_q);
      ovf_q <= !cnt_q[CW-1] && cnt_d[CW-1];
      if (wr_ctl) begin
        ctl_q <= ctl_new;
        run_q <= '0;
        st_q  <= ctl_new.ton_en ? GATE_WAIT : GATE_RUN;
      end else begin
        run_q <= run_d;
        case (st_q)
          GATE_WAIT: if (on_hit) st_q <= GATE_RUN;
          GATE_RUN:  if (ctl_q.toff_en && off_hit) st_q <= GATE_STOP;
          default:   st_q <= st_q;
        endcase
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign ctl_o  = {{(CW-LCTL_W){1'b0}}, ctl_q};
  assign chg_o  = chg_q;
  assign ovf_o  = ovf_q;
  assign cond_o = ctl_q.ovf_en & cnt_q[CW-1];

  // R3: a value write lands exactly
  assert_write_wins_R3: assert property (@(posedge clk) disable iff (rst)
    wr_val |=> cnt_q == $past(wdata));
  // R2: without a write the count moves by at most one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_val |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  // R4: frozen counters hold
  assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ((frz_all || ctl_q.frz) && !wr_val) |=> $stable(cnt_q));
  // R5: a waiting counter holds
  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == GATE_WAIT && !wr_val) |=> $stable(cnt_q));
  // R6: a stopped counter holds until its control word is rewritten
  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == GATE_STOP && !wr_val) |=> $stable(cnt_q));
  assert_stop_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == GATE_STOP && !wr_ctl) |=> st_q == GATE_STOP);
endmodule

// File: rtl/tec_rdmux.sv
module tec_rdmux
  import tec_pkg::*;
#(
  parameter int NCNT = 6,
  parameter int CW   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  gctl_t                    gctl,
  input  logic [NCNT-1:0][CW-1:0]  cnt_all,
  input  logic [NCNT-1:0][CW-1:0]  ctl_all,
  output logic [CW-1:0]            rdata
);
  logic [CW-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    case (addr[4:3])
      REG_GLB: if (addr[2:0] == 3'd0) rd_d = {{(CW-3){1'b0}}, gctl};
      REG_VAL: for (int k = 0; k < NCNT; k++)
                 if (addr[2:0] == 3'(k)) rd_d = cnt_all[k];
      REG_CTL: for (int k = 0; k < NCNT; k++)
                 if (addr[2:0] == 3'(k)) rd_d = ctl_all[k];
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

  // R10: global word appears one cycle after its address
  assert_rd_glob_R10: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |=> rdata == {{(CW-3){1'b0}}, $past(gctl)});
  // R10: counter 0 value appears one cycle after its address
  assert_rd_val_R10: assert property (@(posedge clk) disable iff (rst)
    (addr == {REG_VAL, 3'd0}) |=> rdata == $past(cnt_all[0]));
endmodule

// File: rtl/tec_top.sv
module tec_top
  import tec_pkg::*;
#(
  parameter int NCNT = 6,
  parameter int CW   = 32,
  parameter int NEV  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NEV-1:0]    ev_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  output logic              irq_o
);
  // NCNT up to 8, NEV up to 16, CW at least LCTL_W
  logic [NCNT-1:0][CW-1:0] cnt_all;
  logic [NCNT-1:0][CW-1:0] ctl_all;
  logic [NCNT-1:0]         chg_all;
  logic [NCNT-1:0]         ovf_all;
  logic [NCNT-1:0]         cond_all;
  logic                    frz_all;
  logic                    wr_glb;
  gctl_t                   gctl;

  assign wr_glb = wr_en && (addr == '0);

  tec_glob #(.NCNT(NCNT)) u_glob (
    .clk    (clk),
    .rst    (rst),
    .wr_glb (wr_glb),
    .wbits  (wdata[2:0]),
    .cond_i (cond_all),
    .gctl_o (gctl),
    .frz_o  (frz_all),
    .irq_o  (irq_o)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_slot
    logic wr_val_i;
    logic wr_ctl_i;
    assign wr_val_i = wr_en && (addr == {REG_VAL, 3'(i)});
    assign wr_ctl_i = wr_en && (addr == {REG_CTL, 3'(i)});

    tec_slot #(.NCNT(NCNT), .CW(CW), .NEV(NEV)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_val  (wr_val_i),
      .wr_ctl  (wr_ctl_i),
      .wdata   (wdata),
      .ev_i    (ev_i),
      .chg_all (chg_all),
      .ovf_all (ovf_all),
      .frz_all (frz_all),
      .cnt_o   (cnt_all[i]),
      .ctl_o   (ctl_all[i]),
      .chg_o   (chg_all[i]),
      .ovf_o   (ovf_all[i]),
      .cond_o  (cond_all[i])
    );
  end

  tec_rdmux #(.NCNT(NCNT), .CW(CW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .gctl    (gctl),
    .cnt_all (cnt_all),
    .ctl_all (ctl_all),
    .rdata   (rdata)
  );

  // R1: outputs quiet on the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && rdata == '0));
endmodule

// File: tb/sim_tec_top.sv
module sim_tec_top;
  localparam int NCNT = 6;
  localparam int CW   = 32;
  localparam int NEV  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NEV-1:0] ev = '0;
  logic          wr_en = 1'b0;
  logic [4:0]    addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  tec_top #(.NCNT(NCNT), .CW(CW), .NEV(NEV)) u0 (
    .clk(clk), .rst(rst), .ev_i(ev), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  // threshold table: {thr, mult, pulse length, expected increment}
  localparam logic [17:0] THR_TBL [0:8] = '{
    {8'd3, 1'b0, 8'd3,  1'b0},
    {8'd3, 1'b0, 8'd4,  1'b1},
    {8'd3, 1'b1, 8'd6,  1'b0},
    {8'd3, 1'b1, 8'd7,  1'b1},
    {8'd0, 1'b0, 8'd1,  1'b1},
    {8'd5, 1'b0, 8'd20, 1'b1},
    {8'd2, 1'b1, 8'd4,  1'b0},
    {8'd2, 1'b1, 8'd5,  1'b1},
    {8'd1, 1'b0, 8'd1,  1'b0}
  };

  function automatic logic [CW-1:0] mk(input int evs, input bit ovfe, input bit frz,
                                       input bit ton, input bit toff, input int onsel,
                                       input int offsel, input bit tmode, input bit tmult,
                                       input int thr);
    logic [CW-1:0] w;
    w = '0;
    w[3:0]   = 4'(evs);
    w[4]     = ovfe;
    w[5]     = frz;
    w[6]     = ton;
    w[7]     = toff;
    w[10:8]  = 3'(onsel);
    w[13:11] = 3'(offsel);
    w[14]    = tmode;
    w[15]    = tmult;
    w[23:16] = 8'(thr);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [CW-1:0] v);
    @(negedge clk);
    addr = 5'(a);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic pulse(input int line, input int len);
    @(negedge clk);
    ev[line] = 1'b1;
    repeat (len) @(negedge clk);
    ev[line] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 0);
    chk("R1 rdata after reset", rdata, 0);
    rd(8, v);  chk("R1 value0 after reset", v, 0);
    rd(16, v); chk("R1 ctl0 after reset", v, 0);
    rd(0, v);  chk("R1 global after reset", v, 0);

    // R9 threshold table
    for (int i = 0; i < 9; i++) begin
      logic [17:0] e;
      e = THR_TBL[i];
      wr(16, mk(0, 0, 0, 0, 0, 0, 0, 1, e[9], int'(e[17:10])));
      wr(8, 0);
      pulse(0, int'(e[8:1]));
      idle(3);
      rd(8, v);
      chk($sformatf("R9 threshold row %0d", i), v, {31'd0, e[0]});
    end

    // R2 simple counting, other lines ignored
    wr(16, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(8, 0);
    pulse(2, 5);
    pulse(3, 3);
    idle(2);
    rd(8, v);  chk("R2 simple count", v, 5);
    rd(16, v); chk("R10 ctl readback", v, 32'h2);

    // R3 write beats increment
    @(negedge clk);
    ev[2] = 1'b1; wr_en = 1'b1; addr = 5'd8; wdata = 100;
    @(negedge clk);
    ev[2] = 1'b0; wr_en = 1'b0;
    idle(2);
    rd(8, v); chk("R3 write wins", v, 100);

    // R4 local and global freeze
    wr(16, mk(2, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    pulse(2, 4); idle(2);
    rd(8, v); chk("R4 local freeze", v, 100);
    wr(16, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(0, 1);
    pulse(2, 4); idle(2);
    rd(8, v); chk("R4 global freeze", v, 100);
    wr(0, 0);
    pulse(2, 3); idle(2);
    rd(8, v); chk("R4 resume", v, 103);

    // R5 trigger-on from counter 0 change
    wr(9, 0);
    wr(17, mk(4, 0, 0, 1, 0, 0, 0, 0, 0, 0));
    pulse(4, 3); idle(3);
    rd(9, v); chk("R5 held before trigger", v, 0);
    pulse(2, 1); idle(4);
    pulse(4, 3); idle(2);
    rd(9, v); chk("R5 counts after trigger", v, 3);

    // R6 trigger-off on counter 3 overflow
    wr(19, mk(6, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(11, 32'h7FFF_FFFE);
    wr(18, mk(5, 0, 0, 0, 1, 0, 3, 0, 0, 0));
    wr(10, 0);
    pulse(5, 2); idle(2);
    pulse(6, 1); idle(3);
    pulse(5, 1); idle(2);
    rd(10, v); chk("R6 runs before overflow", v, 3);
    pulse(6, 1); idle(4);
    rd(11, v); chk("R2 peer reached top bit", v, 32'h8000_0000);
    pulse(5, 3); idle(2);
    rd(10, v); chk("R6 stopped", v, 3);
    wr(11, 0);
    pulse(5, 2); idle(2);
    rd(10, v); chk("R6 stays stopped", v, 3);
    wr(18, mk(5, 0, 0, 0, 1, 0, 3, 0, 0, 0));
    pulse(5, 2); idle(2);
    rd(10, v); chk("R6 rearmed by control write", v, 5);

    // R7 interrupt
    wr(20, mk(7, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(12, 32'h7FFF_FFFF);
    wr(0, 2);
    idle(2);
    chk("R7 no irq before overflow", {31'd0, irq}, 0);
    pulse(7, 1); idle(2);
    chk("R7 irq on overflow", {31'd0, irq}, 1);
    wr(20, mk(7, 0, 0, 0, 0, 0, 0, 0, 0, 0)); idle(2);
    chk("R7 cleared by enable off", {31'd0, irq}, 0);
    wr(20, mk(7, 1, 0, 0, 0, 0, 0, 0, 0, 0)); idle(2);
    chk("R7 back with enable on", {31'd0, irq}, 1);
    wr(0, 0); idle(2);
    chk("R7 global gate off", {31'd0, irq}, 0);
    wr(0, 2); idle(2);
    chk("R7 global gate on", {31'd0, irq}, 1);
    wr(12, 5); idle(2);
    chk("R7 cleared by top bit write", {31'd0, irq}, 0);
    wr(11, 32'h8000_0000); idle(2);
    chk("R7 overflow without enable", {31'd0, irq}, 0);

    // R8 freeze on interrupt
    wr(8, 0);
    wr(12, 32'h7FFF_FFFF);
    wr(0, 6);
    pulse(7, 1); idle(2);
    chk("R8 irq raised", {31'd0, irq}, 1);
    pulse(2, 3); idle(2);
    rd(8, v);  chk("R8 bank frozen", v, 0);
    pulse(7, 2); idle(2);
    rd(12, v); chk("R8 source frozen", v, 32'h8000_0000);
    wr(12, 0);
    pulse(2, 2); idle(2);
    rd(8, v);  chk("R8 thaw after clear", v, 2);
    wr(0, 4);
    wr(12, 32'h8000_0000);
    pulse(2, 2); idle(2);
    rd(8, v);  chk("R8 no freeze without irq enable", v, 4);
    chk("R8 irq low without enable", {31'd0, irq}, 0);
    rd(0, v);  chk("R10 global readback", v, 4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule